// File: doc/BRIEF.md
# Sign-sign LMS tap adaptation engine

This block adapts the feedback tap coefficients of a decision-feedback equalizer. Each clock cycle is one unit interval. In each cycle the block takes the current data decision and, when one is available, the sign of an error sample. The error sample comes from comparing the equalized signal against a programmable target level. For each tap H1..H5, the block compares the error sign with the sign of the decision made that many intervals earlier. The block then moves the tap by a fixed step so that the correlation gets smaller. Only signs enter the update, never magnitudes. At convergence, the error no longer tracks any of the past decisions.

The step is a power of two, set by a 3-bit shift. Coefficients are 10-bit two's-complement values that saturate rather than wrap. Adaptation runs only when enable is high and the error sample is marked valid; otherwise the coefficients hold. A load port writes an initial value into any single tap, including while the other taps adapt.

Top module: `sslms_adapt`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, every coefficient on coef_o reads zero.
- R2: Tap Hk (k = 1..5) pairs the error sign of cycle n with the decision presented on dec_i in cycle n-k. Decisions present before reset count as -1. The decision history shifts every cycle, whatever the value of enable or valid.
- R3: On a sampled cycle, a tap moves down by one step when the error sign equals its delayed decision and up by one step when they differ. Encoding: dec_i 1 = +1, 0 = -1; err_sign_i 1 = positive error, 0 = negative. The new value appears on coef_o after the next rising edge.
- R4: The step equals 2^step_shift_i LSB, with step_shift_i from 0 to 7.
- R5: A tap clamps at 511 when moving up and at -512 when moving down. It never wraps.
- R6: When enable_i or err_valid_i is low, no coefficient changes, except a tap that is being loaded.
- R7: When load_i is high, the tap chosen by load_sel_i (0 = H1 .. 4 = H5) takes load_val_i on the next edge, overriding its own adaptation. The other taps adapt as normal in that same cycle. A load_sel_i value of 5 to 7 has no effect.
- R8: coef_o holds Hk in bits [(k-1)*10 +: 10] as two's complement, so H1 sits in bits [9:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one unit interval per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Adaptation enable |
| err_valid_i | input | 1 | Error sample valid in this cycle |
| err_sign_i | input | 1 | Error sign, 1 = positive |
| dec_i | input | 1 | Data decision of this cycle, 1 = +1 |
| step_shift_i | input | 3 | Step as a power-of-two shift |
| load_i | input | 1 | Write one tap |
| load_sel_i | input | 3 | Tap to write, 0 = H1 |
| load_val_i | input | 10 | Value to write, two's complement |
| coef_o | output | 50 | Packed coefficients H1..H5 |

## Verification
A load and an adaptation step can fall in the same cycle. The bench provokes this by driving load_i while enable_i and err_valid_i are high. It judges the result by checking that the selected tap shows exactly load_val_i, while the other four taps show their stepped values from an independent bench model. Saturation and the delay pairing are judged the same way. The bench first loads values near the limits. It then drives constant decision patterns so that the delayed bit and the error sign agree or disagree on purpose.

// File: rtl/sslms_pkg.sv
package sslms_pkg;
  localparam int NUM_TAPS_DEF = 5;
  localparam int COEF_W_DEF   = 10;
  localparam int SHIFT_W_DEF  = 3;

  // 1 when error sign and delayed decision carry the same polarity
  function automatic logic same_sign(logic a, logic b);
    return ~(a ^ b);
  endfunction
endpackage

// File: rtl/sslms_dec_hist.sv
module sslms_dec_hist #(
  parameter int DEPTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  output logic [DEPTH-1:0] hist_o
);
  // hist_o[k] = decision presented k+1 cycles ago
  logic [DEPTH-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= {hist_q[DEPTH-2:0], dec_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/sslms_step_gen.sv
module sslms_step_gen #(
  parameter int COEF_W  = 10,
  parameter int SHIFT_W = 3
) (
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [COEF_W-1:0]  step_o
);
  initial begin
    if ((1 << ((1 << SHIFT_W) - 1)) > (1 << (COEF_W - 2)) * 2 - 1)
      $display("sslms_step_gen: largest step exceeds coefficient range");
  end

  assign step_o = COEF_W'(1) << shift_i;
endmodule

// File: rtl/sslms_tap.sv
module sslms_tap #(
  parameter int COEF_W = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     upd_en_i,
  input  logic                     agree_i,
  input  logic [COEF_W-1:0]        step_i,
  input  logic                     load_i,
  input  logic signed [COEF_W-1:0] load_val_i,
  output logic signed [COEF_W-1:0] coef_o
);
  localparam int MAX_I = (1 << (COEF_W - 1)) - 1;
  localparam int MIN_I = -(1 << (COEF_W - 1));

  logic signed [COEF_W-1:0] coef_q, coef_d;
  logic signed [COEF_W:0]   ext, delta, nxt;

  always_comb begin
    ext   = {coef_q[COEF_W-1], coef_q};
    delta = agree_i ? -$signed({1'b0, step_i}) : $signed({1'b0, step_i});
    nxt   = ext + delta;
    coef_d = coef_q;
    if (load_i) begin
      coef_d = load_val_i;
    end else if (upd_en_i) begin
      if (nxt > MAX_I)      coef_d = COEF_W'(MAX_I);
      else if (nxt < MIN_I) coef_d = COEF_W'(MIN_I);
      else                  coef_d = nxt[COEF_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coef_q <= '0;
    else         coef_q <= coef_d;
  end

  assign coef_o = coef_q;

  // R6
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!upd_en_i) && $past(!load_i)) |-> $stable(coef_q));

  // R3
  agree_moves_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_en_i) && $past(agree_i) && $past(!load_i)) |-> (coef_q <= $past(coef_q)));

  // R5
  no_wrap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(coef_q) == COEF_W'(MAX_I) && $past(upd_en_i) && $past(!agree_i) && $past(!load_i))
      |-> (coef_q == COEF_W'(MAX_I)));

  // R5
  no_wrap_bottom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(coef_q) == COEF_W'(MIN_I) && $past(upd_en_i) && $past(agree_i) && $past(!load_i))
      |-> (coef_q == COEF_W'(MIN_I)));

  // R7
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_i) |-> (coef_q == $past(load_val_i)));
endmodule

// File: rtl/sslms_adapt.sv
module sslms_adapt
  import sslms_pkg::*;
#(
  parameter  int NUM_TAPS = NUM_TAPS_DEF,
  parameter  int COEF_W   = COEF_W_DEF,
  parameter  int SHIFT_W  = SHIFT_W_DEF,
  localparam int SEL_W    = $clog2(NUM_TAPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       enable_i,
  input  logic                       err_valid_i,
  input  logic                       err_sign_i,
  input  logic                       dec_i,
  input  logic [SHIFT_W-1:0]         step_shift_i,
  input  logic                       load_i,
  input  logic [SEL_W-1:0]           load_sel_i,
  input  logic [COEF_W-1:0]          load_val_i,
  output logic [NUM_TAPS*COEF_W-1:0] coef_o
);
  logic [NUM_TAPS-1:0] hist;
  logic [COEF_W-1:0]   step;
  logic                upd_en;

  assign upd_en = enable_i & err_valid_i;

  sslms_dec_hist #(.DEPTH(NUM_TAPS)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dec_i  (dec_i),
    .hist_o (hist)
  );

  sslms_step_gen #(.COEF_W(COEF_W), .SHIFT_W(SHIFT_W)) u_step (
    .shift_i (step_shift_i),
    .step_o  (step)
  );

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    logic                     tap_load;
    logic signed [COEF_W-1:0] tap_coef;

    assign tap_load = load_i && (load_sel_i == SEL_W'(k));

    sslms_tap #(.COEF_W(COEF_W)) u_tap (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .upd_en_i   (upd_en),
      .agree_i    (same_sign(err_sign_i, hist[k])),
      .step_i     (step),
      .load_i     (tap_load),
      .load_val_i ($signed(load_val_i)),
      .coef_o     (tap_coef)
    );

    assign coef_o[k*COEF_W +: COEF_W] = tap_coef;
  end

  // R2
  hist_tracks_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_en) && $past(!load_i) && $past(err_sign_i) == $past(dec_i, 2)
      && $past(coef_o[COEF_W-1:0]) != {1'b1, {(COEF_W-1){1'b0}}})
      |-> ($signed(coef_o[COEF_W-1:0]) < $signed($past(coef_o[COEF_W-1:0]))));
endmodule

// File: tb/sim_sslms_adapt.sv
module sim_sslms_adapt;
  localparam int PERIOD = 10;
  localparam int NT = 5;
  localparam int CW = 10;

  typedef struct packed {
    logic       en;
    logic       vld;
    logic       err;
    logic       dec;
    logic [2:0] sh;
  } vec_t;

  localparam vec_t VEC [0:15] = '{
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd1},
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd2},
    '{1'b1, 1'b1, 1'b0, 1'b0, 3'd3},
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd5},
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd4},
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd6},
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd7},
    '{1'b1, 1'b1, 1'b0, 1'b0, 3'd7},
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd2},
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd1},
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd3},
    '{1'b1, 1'b1, 1'b1, 1'b0, 3'd0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 3'd5},
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd4}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, vld = 1'b0, err = 1'b0, dec = 1'b0, ld = 1'b0;
  logic [2:0]    sh = '0, sel = '0;
  logic [CW-1:0] val = '0;
  logic [NT*CW-1:0] coef;

  int total = 0;
  int bad = 0;
  int expc [NT];
  logic [NT-1:0] bh;

  always #(PERIOD/2) clk = ~clk;

  sslms_adapt u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .err_valid_i(vld),
    .err_sign_i(err), .dec_i(dec), .step_shift_i(sh), .load_i(ld),
    .load_sel_i(sel), .load_val_i(val), .coef_o(coef)
  );

  function automatic int tap_val(int k);
    return int'($signed(coef[k*CW +: CW]));
  endfunction

  task automatic chk(string tag, int k, int exp_v);
    total++;
    if (tap_val(k) != exp_v) begin
      bad++;
      $display("FAIL %s H%0d actual=%0d expected=%0d", tag, k+1, tap_val(k), exp_v);
    end
  endtask

  task automatic chk_all(string tag);
    for (int k = 0; k < NT; k++) chk(tag, k, expc[k]);
  endtask

  // one cycle: inputs set after a falling edge, model stepped, checked at next falling edge
  task automatic cyc(logic e, logic v, logic er, logic d, logic [2:0] s,
                     logic l, logic [2:0] ls, int lv, string tag);
    int nv;
    en = e; vld = v; err = er; dec = d; sh = s; ld = l; sel = ls; val = CW'(lv);
    for (int k = 0; k < NT; k++) begin
      if (l && ls == 3'(k)) begin
        expc[k] = lv;
      end else if (e && v) begin
        nv = (er == bh[k]) ? expc[k] - (1 << s) : expc[k] + (1 << s);
        if (nv > 511) nv = 511;
        if (nv < -512) nv = -512;
        expc[k] = nv;
      end
    end
    bh = {bh[NT-2:0], d};
    @(negedge clk);
    chk_all(tag);
    ld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    for (int k = 0; k < NT; k++) chk("R1", k, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NT; k++) begin expc[k] = 0; end
    bh = '0;
  endtask

  initial begin
    #(PERIOD*100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bh = '0;
    for (int k = 0; k < NT; k++) expc[k] = 0;
    @(negedge clk);
    do_reset();
    // R1: first cycle after release, idle inputs
    cyc(0, 0, 0, 0, 3'd0, 0, 3'd0, 0, "R1");

    // R2 R3 R4: table walk
    for (int i = 0; i < 16; i++)
      cyc(VEC[i].en, VEC[i].vld, VEC[i].err, VEC[i].dec, VEC[i].sh, 0, 3'd0, 0, "R3");

    // R2: impulse in history, only the tap at the matching delay sees +1
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 3'd0, 0, 3'd0, 0, "R6");
    cyc(0, 1, 0, 1, 3'd0, 0, 3'd0, 0, "R6");
    cyc(0, 1, 0, 0, 3'd0, 0, 3'd0, 0, "R6");
    cyc(0, 1, 0, 0, 3'd0, 0, 3'd0, 0, "R6");
    // decision of +1 now sits 3 intervals back: H3 agrees, others disagree
    cyc(1, 1, 1, 0, 3'd2, 0, 3'd0, 0, "R2");

    // R4: largest step
    cyc(1, 1, 0, 1, 3'd7, 0, 3'd0, 0, "R4");

    // R6: hold with enable low, then with valid low
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, i[0], 3'd5, 0, 3'd0, 0, "R6");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, i[0], 3'd5, 0, 3'd0, 0, "R6");

    // R5: top clamp on H1, bottom clamp on H5
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 1, 3'd0, 0, 3'd0, 0, "R6");
    cyc(0, 0, 0, 1, 3'd0, 1, 3'd0, 500, "R7");
    cyc(0, 0, 0, 1, 3'd0, 1, 3'd4, -500, "R7");
    cyc(1, 1, 0, 1, 3'd4, 0, 3'd0, 0, "R5");
    chk("R5", 0, 511);
    cyc(1, 1, 0, 1, 3'd4, 0, 3'd0, 0, "R5");
    chk("R5", 0, 511);
    cyc(1, 1, 1, 1, 3'd4, 0, 3'd0, 0, "R5");
    cyc(0, 0, 0, 1, 3'd0, 1, 3'd4, -500, "R7");
    cyc(1, 1, 1, 1, 3'd4, 0, 3'd0, 0, "R5");
    chk("R5", 4, -512);
    cyc(1, 1, 1, 1, 3'd4, 0, 3'd0, 0, "R5");
    chk("R5", 4, -512);

    // R7: load concurrent with adaptation; out-of-range selector
    cyc(1, 1, 0, 0, 3'd1, 1, 3'd2, 77, "R7");
    chk("R7", 2, 77);
    cyc(1, 1, 1, 0, 3'd1, 1, 3'd6, 200, "R7");
    cyc(0, 0, 0, 0, 3'd0, 1, 3'd5, -3, "R7");

    // R8: field position of a loaded negative value
    cyc(0, 0, 0, 0, 3'd0, 1, 3'd1, -1, "R8");
    total++;
    if (coef[2*CW-1:CW] != 10'h3FF) begin
      bad++;
      $display("FAIL R8 bits[19:10] actual=%h expected=3ff", coef[2*CW-1:CW]);
    end

    // R1: reset mid-run clears loaded taps
    do_reset();
    cyc(1, 0, 0, 0, 3'd0, 0, 3'd0, 0, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule